// File: doc/BRIEF.md
# Frame-Checked Serial Control Port

A 16-bit serial slave front end for a system control device. The host selects the block with an active-low select, shifts a command word in MSB first, and at the same time reads back a status word. The slave samples the serial input on each falling serial clock edge and updates its serial output after each rising edge. The serial clock therefore idles low. Select, clock and data are brought into the system clock domain through two-flop synchronizers, and all edges are detected there.

When select rises, the received word is judged. The block counts falling clock edges modulo the frame length. A frame is accepted only when that count is a nonzero multiple of 16 and the three most significant bits of the last 16 received bits (the mode field) are not the reserved code 000. An accepted word is committed to the control-word output. A rejected word is dropped and the control word keeps its value. A rejection sets a sticky fail flag and, if enabled, pulses an interrupt request. While the fail flag is set, the next frame drives the output line high before its first rising clock edge, and it repeats the previously sent status word instead of taking a new one.

The committed control word is offered on a valid/ready output. `ctrl_valid` rises on each commit and stays high until a clock edge where `ctrl_ready` is high. The serial host cannot be stalled, so there is no back-pressure toward it. A commit that arrives while a word is still pending overwrites that word, and the newest word wins. Decoding of the word is left to the consumer.

Top module: `spi_fchk_top`

## Requirements
- R1: After reset, `spi_miso_oe`, `ctrl_valid`, `spi_fail` and `irq` are 0, and `ctrl_word` equals `CTRL_RESET` (default 0).
- R2: A frame of exactly 16 bits, received MSB first on falling clock edges, whose bits [15:13] are not 000 is committed to `ctrl_word` after select rises, and `ctrl_valid` is set.
- R3: A frame whose falling-edge count is not a nonzero multiple of 16 (0, 15 or 17 bits, for example) is discarded, and `ctrl_word` is left unchanged. A 32-bit frame is accepted and commits its last 16 bits.
- R4: A frame with mode field bits [15:13] equal to 000 is rejected in the same way as a length error.
- R5: A rejected frame sets `spi_fail`, which stays set until the next accepted frame clears it. When `irq_en` is 1, each rejection gives exactly one single-cycle `irq` pulse. When `irq_en` is 0, a rejection gives none.
- R6: `spi_miso_oe` is 1 while selected and 0 after deselect. Between the falling edge of select and the first rising clock edge, `spi_miso` equals the fail flag.
- R7: After the k-th rising clock edge of a frame, `spi_miso` carries bit 16-k of the frame's output word for k = 1..16, and 0 after that. With the fail flag clear, the output word is `status_word` sampled when select falls.
- R8: With the fail flag set when select falls, the output word is the word loaded at the start of the previous frame, and `status_word` is ignored.
- R9: `ctrl_valid` stays high with `ctrl_word` stable until a clock edge where `ctrl_ready` is 1. A new commit sets it again and replaces the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| status_word | input | FRAME_W | Status to send, sampled when select falls |
| irq_en | input | 1 | Interrupt enable for rejected frames |
| ctrl_word | output | FRAME_W | Last committed control word |
| ctrl_valid | output | 1 | Committed word pending |
| ctrl_ready | input | 1 | Consumer takes the pending word |
| spi_fail | output | 1 | Sticky rejected-frame flag |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The hardest state to reach from the ports is a repeat chain: a rejection, then a frame with a changed status input, then another frame. Only then does the bench see whether the repeated word is the held word and not the new status. It also sees whether an accepted frame ends the repeat. The stimulus reaches this state with directed frames of 0, 15, 17 and 32 bits and with a reserved mode code, each followed by a frame carrying a different status. A seeded random phase then mixes frame lengths, mode fields, interrupt enables and consumer handshakes, so that rejections fall on every kind of preceding state.

// File: rtl/spi_fchk_pkg.sv
package spi_fchk_pkg;

  // Outcome of the checks made when select rises.
  typedef struct packed {
    logic ok;
    logic len_bad;
    logic mode_bad;
  } spi_fchk_verdict_t;

endpackage

// File: rtl/spi_fchk_sync.sv
module spi_fchk_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        sync_q <= RST_VAL[g];
      end else begin
        meta_q <= async_in[g];
        sync_q <= meta_q;
      end
    end
    assign sync_out[g] = sync_q;
  end

endmodule

// File: rtl/spi_fchk_rx.sv
module spi_fchk_rx
  import spi_fchk_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int MODE_W    = 3,
  parameter int MODE_RSVD = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sclk_fall,
  input  logic               mosi,
  output logic [FRAME_W-1:0] rx_word,
  output logic               done,
  output spi_fchk_verdict_t  verdict
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   bit_cnt;
  logic               wrapped;
  logic [FRAME_W-1:0] shreg;
  spi_fchk_verdict_t  judge;

  always_comb begin
    judge.len_bad  = !(wrapped && (bit_cnt == '0));
    judge.mode_bad = (shreg[FRAME_W-1 -: MODE_W] == MODE_W'(MODE_RSVD));
    judge.ok       = !judge.len_bad && !judge.mode_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      wrapped <= 1'b0;
      shreg   <= '0;
      rx_word <= '0;
      done    <= 1'b0;
      verdict <= '0;
    end else begin
      done <= cs_rise;
      if (cs_fall) begin
        bit_cnt <= '0;
        wrapped <= 1'b0;
      end else if (sclk_fall) begin
        shreg <= {shreg[FRAME_W-2:0], mosi};
        if (bit_cnt == LAST) begin
          bit_cnt <= '0;
          wrapped <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (cs_rise) begin
        rx_word <= shreg;
        verdict <= judge;
      end
    end
  end

  // R3: a partial count at deselect must yield a rejecting verdict
  assert_len_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != '0) |=> (done && !verdict.ok && verdict.len_bad));

  // R4: reserved mode field at deselect must yield a rejecting verdict
  assert_mode_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && shreg[FRAME_W-1 -: MODE_W] == MODE_W'(MODE_RSVD)) |=> (done && !verdict.ok));

endmodule

// File: rtl/spi_fchk_tx.sv
module spi_fchk_tx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sclk_rise,
  input  logic               fail_flag,
  input  logic [FRAME_W-1:0] status_word,
  output logic               miso,
  output logic               miso_oe
);

  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] held;
  logic [FRAME_W-1:0] load_word;

  // While failed, repeat the word sent at the previous frame start.
  assign load_word = fail_flag ? held : status_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      held    <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      if (cs_fall) begin
        shreg   <= load_word;
        held    <= load_word;
        miso    <= fail_flag;
        miso_oe <= 1'b1;
      end else if (sclk_rise) begin
        miso  <= shreg[FRAME_W-1];
        shreg <= {shreg[FRAME_W-2:0], 1'b0};
      end
      if (cs_rise) begin
        miso_oe <= 1'b0;
      end
    end
  end

  // R6: the fail bit is presented once select falls
  assert_fail_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (miso == $past(fail_flag) && miso_oe));

  // R6: deselect releases the output
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !miso_oe);

  // R7: the output line only moves at frame start or after a rising clock
  assert_miso_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_fall && !sclk_rise) |=> $stable(miso));

endmodule

// File: rtl/spi_fchk_ctl.sv
module spi_fchk_ctl
  import spi_fchk_pkg::*;
#(
  parameter int                FRAME_W    = 16,
  parameter logic [FRAME_W-1:0] CTRL_RESET = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done,
  input  spi_fchk_verdict_t  verdict,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic               irq_en,
  input  logic               ctrl_ready,
  output logic [FRAME_W-1:0] ctrl_word,
  output logic               ctrl_valid,
  output logic               spi_fail,
  output logic               irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word  <= CTRL_RESET;
      ctrl_valid <= 1'b0;
      spi_fail   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (done && verdict.ok) begin
        ctrl_word  <= rx_word;
        ctrl_valid <= 1'b1;
        spi_fail   <= 1'b0;
      end else begin
        if (done) begin
          spi_fail <= 1'b1;
          irq      <= irq_en;
        end
        if (ctrl_valid && ctrl_ready) begin
          ctrl_valid <= 1'b0;
        end
      end
    end
  end

  // R2: an accepted frame lands in the control word
  assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && verdict.ok) |=> (ctrl_valid && ctrl_word == $past(rx_word) && !spi_fail));

  // R5: a rejection leaves the word alone and raises the flag
  assert_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !verdict.ok) |=> (spi_fail && $stable(ctrl_word)));

  // R5: interrupt only follows a rejection with interrupts enabled
  assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done && !verdict.ok && irq_en));

  // R9: a pending word holds until taken
  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_valid && !ctrl_ready && !done) |=> (ctrl_valid && $stable(ctrl_word)));

endmodule

// File: rtl/spi_fchk_top.sv
module spi_fchk_top
  import spi_fchk_pkg::*;
#(
  parameter int                FRAME_W    = 16,
  parameter int                MODE_W     = 3,
  parameter int                MODE_RSVD  = 0,
  parameter logic [FRAME_W-1:0] CTRL_RESET = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_csn,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic               spi_miso_oe,
  input  logic [FRAME_W-1:0] status_word,
  input  logic               irq_en,
  output logic [FRAME_W-1:0] ctrl_word,
  output logic               ctrl_valid,
  input  logic               ctrl_ready,
  output logic               spi_fail,
  output logic               irq
);

  // bit 0 sclk, bit 1 csn, bit 2 mosi
  logic [2:0] pins_s;
  logic       sclk_q;
  logic       csn_q;
  logic       cs_fall;
  logic       cs_rise;
  logic       sclk_fall;
  logic       sclk_rise;
  logic [FRAME_W-1:0] rx_word;
  logic               done;
  spi_fchk_verdict_t  verdict;

  spi_fchk_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({spi_mosi, spi_csn, spi_sclk}),
    .sync_out (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= pins_s[0];
      csn_q  <= pins_s[1];
    end
  end

  assign cs_fall   = csn_q && !pins_s[1];
  assign cs_rise   = !csn_q && pins_s[1];
  assign sclk_rise = !pins_s[1] && !sclk_q && pins_s[0];
  assign sclk_fall = !pins_s[1] && sclk_q && !pins_s[0];

  spi_fchk_rx #(.FRAME_W(FRAME_W), .MODE_W(MODE_W), .MODE_RSVD(MODE_RSVD)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .mosi      (pins_s[2]),
    .rx_word   (rx_word),
    .done      (done),
    .verdict   (verdict)
  );

  spi_fchk_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .sclk_rise   (sclk_rise),
    .fail_flag   (spi_fail),
    .status_word (status_word),
    .miso        (spi_miso),
    .miso_oe     (spi_miso_oe)
  );

  spi_fchk_ctl #(.FRAME_W(FRAME_W), .CTRL_RESET(CTRL_RESET)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .verdict    (verdict),
    .rx_word    (rx_word),
    .irq_en     (irq_en),
    .ctrl_ready (ctrl_ready),
    .ctrl_word  (ctrl_word),
    .ctrl_valid (ctrl_valid),
    .spi_fail   (spi_fail),
    .irq        (irq)
  );

  // R1: nothing is driven onto the bus right after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!spi_miso_oe && !irq));

endmodule

// File: tb/spi_fchk_top_tb_top.sv
module spi_fchk_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_csn = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic        spi_miso_oe;
  logic [15:0] status_word = '0;
  logic        irq_en = 1'b0;
  logic [15:0] ctrl_word;
  logic        ctrl_valid;
  logic        ctrl_ready = 1'b0;
  logic        spi_fail;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit finished = 0;

  // model state
  logic        fail_m = 1'b0;
  logic [15:0] held_m = '0;
  logic [15:0] ctrl_m = '0;
  logic        valid_m = 1'b0;

  always #5 clk = ~clk;

  spi_fchk_top dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .status_word(status_word), .irq_en(irq_en), .ctrl_word(ctrl_word),
    .ctrl_valid(ctrl_valid), .ctrl_ready(ctrl_ready), .spi_fail(spi_fail),
    .irq(irq)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic frame_ok(input int n, input logic [15:0] w);
    return (n > 0) && (n % 16 == 0) && (w[15:13] != 3'b000);
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [63:0] d, input logic [15:0] st,
                      input logic ien);
    logic [15:0] word_m;
    logic [15:0] got;
    logic [15:0] mask;
    logic        tail_zero;
    logic        ok;
    int          irq0;
    word_m = fail_m ? held_m : st;
    got = '0;
    tail_zero = 1'b1;
    status_word = st;
    irq_en = ien;
    irq0 = irq_cnt;
    @(negedge clk) spi_csn = 1'b0;
    wait_n(8);
    chk("R6", "oe while selected", {31'd0, spi_miso_oe}, 32'd1);
    chk("R6", "fail bit before first clock", {31'd0, spi_miso}, {31'd0, fail_m});
    status_word = ~st;
    for (int k = 1; k <= n; k++) begin
      spi_mosi = d[n-k];
      spi_sclk = 1'b1;
      wait_n(8);
      if (k <= 16) got[16-k] = spi_miso;
      else if (spi_miso !== 1'b0) tail_zero = 1'b0;
      spi_sclk = 1'b0;
      wait_n(8);
    end
    mask = (n >= 16) ? 16'hFFFF : ~(16'hFFFF >> n);
    if (n > 0)
      chk(fail_m ? "R8" : "R7", "output word", {16'd0, got & mask}, {16'd0, word_m & mask});
    if (n > 16) chk("R7", "zeros after word", {31'd0, tail_zero}, 32'd1);
    held_m = word_m;
    spi_csn = 1'b1;
    wait_n(12);
    ok = frame_ok(n, d[15:0]);
    if (ok) begin
      ctrl_m = d[15:0];
      fail_m = 1'b0;
      valid_m = 1'b1;
    end else begin
      fail_m = 1'b1;
    end
    chk("R6", "oe after deselect", {31'd0, spi_miso_oe}, 32'd0);
    chk(ok ? "R2" : ((n > 0 && n % 16 == 0) ? "R4" : "R3"), "ctrl_word",
        {16'd0, ctrl_word}, {16'd0, ctrl_m});
    chk("R5", "spi_fail", {31'd0, spi_fail}, {31'd0, fail_m});
    chk("R5", "irq pulses", irq_cnt - irq0, (!ok && ien) ? 32'd1 : 32'd0);
    chk("R9", "ctrl_valid", {31'd0, ctrl_valid}, {31'd0, valid_m});
  endtask

  task automatic take();
    @(negedge clk) ctrl_ready = 1'b1;
    @(negedge clk) ctrl_ready = 1'b0;
    valid_m = 1'b0;
    wait_n(1);
    chk("R9", "valid drops after ready", {31'd0, ctrl_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int n;
    logic [63:0] d;
    seed_dummy = $urandom(32'h00C0FFEE);
    wait_n(4);
    // R1: reset values
    chk("R1", "oe at reset", {31'd0, spi_miso_oe}, 32'd0);
    chk("R1", "ctrl_word at reset", {16'd0, ctrl_word}, 32'd0);
    chk("R1", "valid/fail/irq at reset", {29'd0, ctrl_valid, spi_fail, irq}, 32'd0);
    rst_n = 1'b1;
    wait_n(4);

    // directed corner cases
    xfer(16, 64'hA5C3, 16'h1234, 1'b1);         // R2 accept
    xfer(16, 64'h9F01, 16'h4321, 1'b1);         // R9 overwrite while pending
    take();
    xfer(15, 64'h7FFF, 16'hBEEF, 1'b1);         // R3 short
    xfer(16, 64'hE00E, 16'h5555, 1'b1);         // R8 repeat, then accept
    xfer(17, 64'h1FFFF, 16'h0F0F, 1'b0);        // R3 long, irq masked
    xfer(0,  64'h0, 16'h3333, 1'b1);            // R3 empty, still failed
    xfer(16, 64'h1ABC, 16'h7777, 1'b1);         // R4 reserved mode
    xfer(32, 64'h0000_1111_6DB6, 16'h2468, 1'b1); // R3 32 bits accepted
    take();

    // seeded random frames
    for (int i = 0; i < 40; i++) begin
      case ($urandom_range(0, 4))
        0: n = $urandom_range(0, 20);
        1: n = 32;
        default: n = 16;
      endcase
      d = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) d[15:13] = 3'b000;
      xfer(n, d, 16'($urandom()), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 2) == 0 && valid_m) take();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule